// File: doc/BRIEF.md
# ADC Channel and Configuration Command Decoder

This block sits behind a byte-oriented serial slave front end, such as an I2C target, and turns the command bytes written after the address phase into the channel selection and conversion settings of a multiplexed delta-sigma converter. A write carries up to two bytes. The first byte starts with a three-bit prefix that decides whether its low five bits replace the input channel. The optional second byte starts with its own enable bit that gates a new temperature, line-rejection, speed and gain setting.

Bytes are staged while they arrive and are committed together when the bus reports a stop condition. A transaction that is cut short therefore never disturbs the active settings. The decoder accepts commands only between conversions: after the converter reports completion and before the next start. Each commit issues a one-cycle start strobe to the converter core. From reset the block launches a first conversion on its own, using the default settings. The decoder also presents the selected positive and negative mux inputs in decoded form.

Top module: `adc_cmd_decoder`

## Requirements
- R1: A synchronous reset sets the channel to differential, with positive input 0 and negative input 1. It clears every configuration output and the error flag. `conv_start` pulses in the first cycle after the first clock edge with reset low.
- R2: `conv_start` is high for exactly one cycle. In an idle period, a stop condition raises it in the cycle after the stop. The committed settings are already visible on the outputs in that same cycle.
- R3: A first byte whose bits [7:5] are 101 loads the channel from bits [4:0]: bit 4 single-ended, bit 3 odd, bits [2:0] pair address.
- R4: A first byte whose bits [7:5] are 000 or 100 changes neither the channel nor the configuration, whatever the other bits and the second byte hold.
- R5: Any other prefix in the first byte is treated as no update. It also sets `preamble_err`, which stays high until reset.
- R6: A second byte updates the configuration only if its bit 7 is 1 and the first byte carried prefix 101. Bit 6 maps to `cfg_temp`, bit 5 to `cfg_rej_a`, bit 4 to `cfg_rej_b`, bit 3 to `cfg_fast` and bits [2:0] to `cfg_gain`.
- R7: A third or later byte in the same transaction has no effect.
- R8: While a conversion is running (from a start until `conv_done`), bytes and stop conditions are ignored, and no start is issued.
- R9: Bytes that are not yet followed by a stop leave every output unchanged. The settings change only in the cycle in which `conv_start` is high.
- R10: In differential mode, `pos_ch` = {addr, odd} and `neg_ch` = {0, addr, not odd}.
- R11: In single-ended mode, `pos_ch` = {addr, odd} and `neg_ch` is 16, the common-pin code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received command byte |
| rx_byte | input | 8 | Received byte, MSB first on the wire |
| rx_stop | input | 1 | One-cycle strobe: stop condition seen on the bus |
| conv_done | input | 1 | One-cycle strobe from the core: conversion finished |
| conv_start | output | 1 | One-cycle strobe to the core: start a conversion |
| chan_single | output | 1 | Active mode: 1 single-ended, 0 differential |
| pos_ch | output | 4 | Positive mux input index |
| neg_ch | output | 5 | Negative mux input index, 16 = common pin |
| cfg_temp | output | 1 | Temperature measurement select |
| cfg_rej_a | output | 1 | Rejection select bit A |
| cfg_rej_b | output | 1 | Rejection select bit B |
| cfg_fast | output | 1 | 2x speed mode (auto-calibration off) |
| cfg_gain | output | 3 | Gain code |
| preamble_err | output | 1 | Sticky flag: illegal first-byte prefix received |

## Verification
The assertions assume that the front end never raises `rx_valid` and `rx_stop` in the same cycle. They also assume the reset is held for more than one clock, so the first sampled past values are the reset values. The bench drives every strobe for exactly one cycle from the falling edge and always separates a byte from the following stop by at least one cycle. It raises `conv_done` only when it intends to open an idle period. The single exception is the busy-period test, which sends bytes and a stop on purpose while a conversion is running.

// File: rtl/adc_cmd_pkg.sv
`timescale 1ns/1ps
package adc_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int GAIN_W = 3;
  localparam int PRE_W  = 3;
  localparam int CH_W   = ADDR_W + 1;
  localparam int NEG_W  = CH_W + 1;

  typedef struct packed {
    logic              single;
    logic              odd;
    logic [ADDR_W-1:0] addr;
  } chan_sel_t;

  typedef struct packed {
    logic              temp;
    logic              rej_a;
    logic              rej_b;
    logic              fast;
    logic [GAIN_W-1:0] gain;
  } conv_cfg_t;

  localparam int CHAN_FLD_W = $bits(chan_sel_t);
  localparam int CFG_FLD_W  = $bits(conv_cfg_t);

  localparam chan_sel_t CHAN_DEFAULT = '0;
  localparam conv_cfg_t CFG_DEFAULT  = '0;

  localparam logic [PRE_W-1:0] PRE_HOLD_A = 3'b000;
  localparam logic [PRE_W-1:0] PRE_HOLD_B = 3'b100;
  localparam logic [PRE_W-1:0] PRE_LOAD   = 3'b101;

  localparam logic [NEG_W-1:0] NEG_COMMON = NEG_W'(1) << CH_W;

  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_CONV = 2'd1,
    ST_IDLE = 2'd2
  } dec_state_t;
endpackage

// File: rtl/adc_cmd_rx.sv
`timescale 1ns/1ps
module adc_cmd_rx
  import adc_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_stop,
  output chan_sel_t         stg_chan,
  output logic              stg_chan_vld,
  output conv_cfg_t         stg_cfg,
  output logic              stg_cfg_vld,
  output logic              bad_pre
);
  localparam int IDX_W = 2;
  localparam logic [IDX_W-1:0] IDX_SAT = 2'd2;

  logic [IDX_W-1:0] idx;
  logic [PRE_W-1:0] pre;
  logic             take;
  logic             pre_legal;

  assign take      = accept && rx_valid;
  assign pre       = rx_byte[BYTE_W-1 -: PRE_W];
  assign pre_legal = (pre == PRE_HOLD_A) || (pre == PRE_HOLD_B) || (pre == PRE_LOAD);
  assign bad_pre   = take && (idx == '0) && !pre_legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx          <= '0;
      stg_chan     <= CHAN_DEFAULT;
      stg_chan_vld <= 1'b0;
      stg_cfg      <= CFG_DEFAULT;
      stg_cfg_vld  <= 1'b0;
    end else if (rx_stop) begin
      idx          <= '0;
      stg_chan_vld <= 1'b0;
      stg_cfg_vld  <= 1'b0;
    end else if (take) begin
      if (idx != IDX_SAT) idx <= idx + 1'b1;
      if (idx == '0) begin
        if (pre == PRE_LOAD) begin
          stg_chan     <= chan_sel_t'(rx_byte[CHAN_FLD_W-1:0]);
          stg_chan_vld <= 1'b1;
        end
      end else if (idx == 2'd1) begin
        if (stg_chan_vld && rx_byte[BYTE_W-1]) begin
          stg_cfg     <= conv_cfg_t'(rx_byte[CFG_FLD_W-1:0]);
          stg_cfg_vld <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_mux_decode.sv
`timescale 1ns/1ps
module adc_mux_decode
  import adc_cmd_pkg::*;
(
  input  chan_sel_t        sel,
  output logic [CH_W-1:0]  pos,
  output logic [NEG_W-1:0] neg
);
  always_comb begin
    pos = {sel.addr, sel.odd};
    if (sel.single) neg = NEG_COMMON;
    else            neg = {1'b0, sel.addr, ~sel.odd};
  end
endmodule

// File: rtl/adc_cmd_decoder.sv
`timescale 1ns/1ps
module adc_cmd_decoder
  import adc_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_stop,
  input  logic              conv_done,
  output logic              conv_start,
  output logic              chan_single,
  output logic [CH_W-1:0]   pos_ch,
  output logic [NEG_W-1:0]  neg_ch,
  output logic              cfg_temp,
  output logic              cfg_rej_a,
  output logic              cfg_rej_b,
  output logic              cfg_fast,
  output logic [GAIN_W-1:0] cfg_gain,
  output logic              preamble_err
);
  dec_state_t       state;
  chan_sel_t        stg_chan;
  conv_cfg_t        stg_cfg;
  logic             stg_chan_vld, stg_cfg_vld, bad_pre;
  logic [CH_W-1:0]  dec_pos, dec_neg_unused_pos;
  logic [NEG_W-1:0] dec_neg, def_neg;
  conv_cfg_t        cfg_q;

  adc_cmd_rx u_rx (
    .clk(clk), .rst(rst), .accept(state == ST_IDLE),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_stop(rx_stop),
    .stg_chan(stg_chan), .stg_chan_vld(stg_chan_vld),
    .stg_cfg(stg_cfg), .stg_cfg_vld(stg_cfg_vld), .bad_pre(bad_pre)
  );

  adc_mux_decode u_dec_new (.sel(stg_chan), .pos(dec_pos), .neg(dec_neg));
  adc_mux_decode u_dec_def (.sel(CHAN_DEFAULT), .pos(dec_neg_unused_pos), .neg(def_neg));

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_BOOT;
      conv_start   <= 1'b0;
      chan_single  <= CHAN_DEFAULT.single;
      pos_ch       <= {CHAN_DEFAULT.addr, CHAN_DEFAULT.odd};
      neg_ch       <= def_neg;
      cfg_q        <= CFG_DEFAULT;
      preamble_err <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      if (bad_pre) preamble_err <= 1'b1;
      case (state)
        ST_BOOT: begin
          conv_start <= 1'b1;
          state      <= ST_CONV;
        end
        ST_CONV: begin
          if (conv_done) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (rx_stop) begin
            if (stg_chan_vld) begin
              chan_single <= stg_chan.single;
              pos_ch      <= dec_pos;
              neg_ch      <= dec_neg;
            end
            if (stg_cfg_vld) cfg_q <= stg_cfg;
            conv_start <= 1'b1;
            state      <= ST_CONV;
          end
        end
        default: state <= ST_BOOT;
      endcase
    end
  end

  assign cfg_temp  = cfg_q.temp;
  assign cfg_rej_a = cfg_q.rej_a;
  assign cfg_rej_b = cfg_q.rej_b;
  assign cfg_fast  = cfg_q.fast;
  assign cfg_gain  = cfg_q.gain;

  logic unused_ok;
  assign unused_ok = ^dec_neg_unused_pos;
endmodule

// File: rtl/adc_cmd_decoder_chk.sv
`timescale 1ns/1ps
module adc_cmd_decoder_chk
  import adc_cmd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic [BYTE_W-1:0] rx_byte,
  input logic              rx_stop,
  input logic              conv_done,
  input logic              conv_start,
  input logic              chan_single,
  input logic [CH_W-1:0]   pos_ch,
  input logic [NEG_W-1:0]  neg_ch,
  input logic              cfg_temp,
  input logic              cfg_rej_a,
  input logic              cfg_rej_b,
  input logic              cfg_fast,
  input logic [GAIN_W-1:0] cfg_gain,
  input logic              preamble_err
);
  logic unused_in;
  assign unused_in = ^{rx_byte, conv_done};

  assert_start_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  assert_change_only_at_start_R9: assert property (@(posedge clk) disable iff (rst)
    !conv_start |-> $stable({chan_single, pos_ch, neg_ch, cfg_temp, cfg_rej_a,
                             cfg_rej_b, cfg_fast, cfg_gain}));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    preamble_err |=> preamble_err);

  assert_single_common_R11: assert property (@(posedge clk) disable iff (rst)
    chan_single |-> (neg_ch == NEG_COMMON));

  assert_diff_adjacent_R10: assert property (@(posedge clk) disable iff (rst)
    !chan_single |-> (neg_ch[NEG_W-1] == 1'b0 && neg_ch[CH_W-1:1] == pos_ch[CH_W-1:1]
                      && neg_ch[0] != pos_ch[0]));

  assert_no_start_on_byte_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_stop) |=> !conv_start);
endmodule

bind adc_cmd_decoder adc_cmd_decoder_chk i_chk (.*);

// File: tb/test_adc_cmd_decoder.sv
`timescale 1ns/1ps
module test_adc_cmd_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       rx_stop = 1'b0;
  logic       conv_done = 1'b0;
  logic       conv_start, chan_single, cfg_temp, cfg_rej_a, cfg_rej_b, cfg_fast, preamble_err;
  logic [3:0] pos_ch;
  logic [4:0] neg_ch;
  logic [2:0] cfg_gain;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adc_cmd_decoder i_adc_cmd_decoder (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_stop(rx_stop),
    .conv_done(conv_done), .conv_start(conv_start), .chan_single(chan_single),
    .pos_ch(pos_ch), .neg_ch(neg_ch), .cfg_temp(cfg_temp), .cfg_rej_a(cfg_rej_a),
    .cfg_rej_b(cfg_rej_b), .cfg_fast(cfg_fast), .cfg_gain(cfg_gain),
    .preamble_err(preamble_err)
  );

  // {b0, b1, nbytes, pos, neg, cfg{temp,rej_a,rej_b,fast,gain}, err}
  localparam int NVEC = 9;
  localparam logic [34:0] VEC [NVEC] = '{
    {8'hA3, 8'h00, 2'd1, 4'd6,  5'd7,  7'h00, 1'b0},
    {8'hBD, 8'hDA, 2'd2, 4'd11, 5'd16, 7'h5A, 1'b0},
    {8'h1F, 8'hFF, 2'd2, 4'd11, 5'd16, 7'h5A, 1'b0},
    {8'h95, 8'hC5, 2'd2, 4'd11, 5'd16, 7'h5A, 1'b0},
    {8'hAF, 8'h7F, 2'd2, 4'd15, 5'd14, 7'h5A, 1'b0},
    {8'hC0, 8'h80, 2'd2, 4'd15, 5'd14, 7'h5A, 1'b1},
    {8'hA0, 8'hA7, 2'd2, 4'd0,  5'd1,  7'h27, 1'b1},
    {8'h00, 8'h00, 2'd0, 4'd0,  5'd1,  7'h27, 1'b1},
    {8'hB1, 8'h89, 2'd3, 4'd2,  5'd16, 7'h09, 1'b1}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic send_stop();
    @(negedge clk); rx_stop = 1'b1;
    @(negedge clk); rx_stop = 1'b0;
  endtask

  task automatic finish_conv();
    @(negedge clk); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  function automatic int cfg_now();
    return {cfg_temp, cfg_rej_a, cfg_rej_b, cfg_fast, cfg_gain};
  endfunction

  task automatic check_defaults(input string tag);
    chk("R1", {tag, " single"}, chan_single, 0);
    chk("R1", {tag, " pos"}, pos_ch, 0);
    chk("R1", {tag, " neg"}, neg_ch, 1);
    chk("R1", {tag, " cfg"}, cfg_now(), 0);
    chk("R1", {tag, " err"}, preamble_err, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", "no start during reset release", conv_start, 0);
    @(negedge clk);
    chk("R1", "auto start after reset", conv_start, 1);
    check_defaults("reset");
    @(negedge clk);
    chk("R2", "boot start width", conv_start, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    do_reset();

    // Table walk: R3 R4 R5 R6 R7 R10 R11 R2
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] b0, b1;
      int n;
      b0 = VEC[v][34:27];
      b1 = VEC[v][26:19];
      n  = VEC[v][18:17];
      finish_conv();
      if (n > 0) send_byte(b0);
      if (n > 1) send_byte(b1);
      if (n > 2) send_byte(8'hBF);
      @(negedge clk); rx_stop = 1'b1;
      @(negedge clk); rx_stop = 1'b0;
      chk("R2", $sformatf("vec%0d start", v), conv_start, 1);
      chk("R3", $sformatf("vec%0d pos", v), pos_ch, VEC[v][16:13]);
      chk("R10", $sformatf("vec%0d neg", v), neg_ch, VEC[v][12:8]);
      chk("R6", $sformatf("vec%0d cfg", v), cfg_now(), VEC[v][7:1]);
      chk("R5", $sformatf("vec%0d err", v), preamble_err, VEC[v][0]);
      chk("R11", $sformatf("vec%0d single", v), chan_single, (VEC[v][12:8] == 5'd16) ? 1 : 0);
      @(negedge clk);
      chk("R2", $sformatf("vec%0d start width", v), conv_start, 0);
    end

    // R8: bytes and stop during a running conversion are ignored
    send_byte(8'hA5);
    send_stop();
    chk("R8", "no start while busy", conv_start, 0);
    chk("R8", "pos kept while busy", pos_ch, 2);
    chk("R8", "neg kept while busy", neg_ch, 16);

    // R9: staged bytes without stop change nothing; stop commits them
    finish_conv();
    send_byte(8'hA5);
    send_byte(8'h8F);
    repeat (3) @(negedge clk);
    chk("R9", "pos before stop", pos_ch, 2);
    chk("R9", "cfg before stop", cfg_now(), 7'h09);
    chk("R9", "no start before stop", conv_start, 0);
    @(negedge clk); rx_stop = 1'b1;
    @(negedge clk); rx_stop = 1'b0;
    chk("R9", "commit start", conv_start, 1);
    chk("R9", "commit pos", pos_ch, 10);
    chk("R9", "commit neg", neg_ch, 11);
    chk("R9", "commit cfg", cfg_now(), 7'h0F);

    // R7: third byte with a load prefix does not reload the channel
    finish_conv();
    send_byte(8'h95);
    send_byte(8'h00);
    send_byte(8'hBF);
    send_stop();
    chk("R7", "third byte ignored pos", pos_ch, 10);

    // R1: reset again restores defaults
    do_reset();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule